// File: doc/BRIEF.md
# Multi-channel PWM timer

This block is a timer core that drives four pulse-width-modulated outputs from one time base. An input prescaler divides the clock into counter ticks. A single counter runs against an auto-reload limit. Four compare channels each compare that counter with their own threshold. Because every channel reads the same counter, all outputs share one period and each channel sets only its own pulse length.

The counter has two modes. In edge-aligned mode it counts up and wraps to zero. In center-aligned mode it counts up to the limit and then back down to zero. A one-cycle update pulse marks each wrap or turnaround.

A simple write port carries the settings. The divider, the limit, the compare thresholds and the counting mode are first held in shadow copies. The running logic picks them up only at an update event, so no period is ever cut short. While the timer is stopped, the shadow copies pass straight through.

Top module: `pwm_timer`

## Requirements
- R1: The counter advances once every PSC+1 clock cycles, where PSC is the active divider value. Between ticks the counter holds its value.
- R2: In edge-aligned mode (control bit 1 = 0) the counter runs 0,1,…,ARR and then wraps to 0. Update events are (ARR+1)·(PSC+1) cycles apart. `upd_evt` is high for the one cycle in which the counter first shows 0 after a wrap. With ARR = 0 it is high on every tick.
- R3: In center-aligned mode (control bit 1 = 1, ARR ≥ 1) the counter runs 0 up to ARR and back down to 0. `upd_evt` is high in the cycle the counter first shows ARR and in the cycle it first shows 0 on the way down. These events are ARR·(PSC+1) cycles apart.
- R4: A channel output is high while the counter is below that channel's active compare value CCR. Over one period this gives a high time of CCR·(PSC+1) cycles in edge-aligned mode and (2·CCR−1)·(PSC+1) cycles in center-aligned mode, for 1 ≤ CCR ≤ ARR.
- R5: With CCR = 0 the output stays low for the whole period. With CCR > ARR it stays high for the whole period.
- R6: Writes to the divider, the limit, the compare values and the mode bit go to shadow registers. They reach the running logic only at an update event, or at any edge while the timer is stopped.
- R7: A channel whose enable bit is clear drives 0 from the cycle after the write, while the counter keeps running. Clearing the run bit holds the counter at 0, drives every output low and stops update events from the second cycle after the write. After reset all outputs and `upd_evt` are 0.
- R8: The write map is as follows. Address 0 is control: bit 0 runs the timer, bit 1 selects the mode, and bit 4+i enables channel i. Address 1 is the divider (PSC). Address 2 is the auto-reload limit (ARR). Address 4+i is the compare value of channel i. A write to address 3 changes nothing.
- R9: All channels share one period and have independent high times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Write address (see R8) |
| wr_data | input | 16 | Write data |
| pwm_out | output | 4 | Channel outputs, bit i is channel i |
| upd_evt | output | 1 | One-cycle update-event pulse |

## Verification
Some rules are checked by the assertions on every cycle:
- the divider phase never passes the active divider value;
- the counter moves only on a tick;
- an edge-aligned update always shows the counter at zero;
- a center-aligned update shows the counter at an endpoint;
- compare values never change between update events while the timer runs;
- a stopped timer stays silent.

Other behaviour can only be shown by the bench scenarios:
- the actual period lengths;
- the high-time counts per channel in both modes;
- that a compare write made in the middle of a period is deferred;
- the effect of channel enables;
- that the unused address is ignored.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;

    typedef enum logic {
        CNT_EDGE   = 1'b0,
        CNT_CENTER = 1'b1
    } cnt_mode_e;

    // write map
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_DIV      = 1;
    localparam int ADDR_LIMIT    = 2;
    localparam int ADDR_CMP_BASE = 4;

    // control word fields
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_MODE_BIT = 1;
    localparam int CTRL_CH_LSB   = 4;

endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] div,
    output logic          tick
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] phase;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = run && (s_q.phase == div);
        if (!run || tick) begin
            s_d.phase = '0;
        end else begin
            s_d.phase = s_q.phase + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase <= div) else $error("divider phase beyond limit"); // R1

endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter
    import pwm_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  cnt_mode_e     mode,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] cnt,
    output logic          turn,
    output logic          upd
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          down;
        logic          upd;
    } ctr_t;

    ctr_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        turn = 1'b0;
        if (!run) begin
            s_d.cnt  = '0;
            s_d.down = 1'b0;
        end else if (tick) begin
            if (limit == '0) begin
                s_d.cnt  = '0;
                s_d.down = 1'b0;
                turn     = 1'b1;
            end else if (mode == CNT_EDGE) begin
                s_d.down = 1'b0;
                if (s_q.cnt >= limit) begin
                    s_d.cnt = '0;
                    turn    = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + ONE;
                end
            end else if (!s_q.down) begin
                if (s_q.cnt >= limit) begin
                    // limit shrank below a count left from a previous setting
                    s_d.cnt  = s_q.cnt - ONE;
                    s_d.down = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + ONE;
                    if (s_q.cnt == limit - ONE) begin
                        s_d.down = 1'b1;
                        turn     = 1'b1;
                    end
                end
            end else begin
                if (s_q.cnt == '0) begin
                    s_d.cnt  = ONE;
                    s_d.down = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                    if (s_q.cnt == ONE) begin
                        s_d.down = 1'b0;
                        turn     = 1'b1;
                    end
                end
            end
        end
        s_d.upd = turn;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;
    assign upd = s_q.upd;

    AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && !$past(tick) |-> $stable(s_q.cnt)) else $error("count moved without tick"); // R1
    AST_EDGE_UPD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.upd && ($past(mode) == CNT_EDGE) |-> s_q.cnt == '0) else $error("edge update off zero"); // R2
    AST_CENTER_UPD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.upd && ($past(mode) == CNT_CENTER) && ($past(limit) != '0)
        |-> (s_q.cnt == '0) || (s_q.cnt == $past(limit))) else $error("center update off endpoint"); // R3
    AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.cnt == '0) && !s_q.upd) else $error("stopped counter moved"); // R7

endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel #(
    parameter int CW = 16
) (
    input  logic          run,
    input  logic          on,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    output logic          pwm
);
    always_comb begin
        pwm = run && on && (cnt < cmp);
    end
endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int  NCH = 4,
    parameter int  CW  = 16,
    localparam int AW  = $clog2(ADDR_CMP_BASE + NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [NCH-1:0] pwm_out,
    output logic           upd_evt
);
    typedef struct packed {
        logic                    run;
        logic [NCH-1:0]          ch_on;
        logic                    mode_sh;
        logic                    mode_act;
        logic [CW-1:0]           div_sh;
        logic [CW-1:0]           div_act;
        logic [CW-1:0]           lim_sh;
        logic [CW-1:0]           lim_act;
        logic [NCH-1:0][CW-1:0]  cmp_sh;
        logic [NCH-1:0][CW-1:0]  cmp_act;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        run: 1'b0, ch_on: '0, mode_sh: 1'b0, mode_act: 1'b0,
        div_sh: '0, div_act: '0, lim_sh: '1, lim_act: '1,
        cmp_sh: '0, cmp_act: '0
    };

    cfg_t          c_d, c_q;
    logic          tick;
    logic          turn;
    logic          load;
    logic [CW-1:0] cnt;

    always_comb begin
        c_d = c_q;
        if (wr_en) begin
            if (wr_addr == AW'(ADDR_CTRL)) begin
                c_d.run     = wr_data[CTRL_RUN_BIT];
                c_d.mode_sh = wr_data[CTRL_MODE_BIT];
                c_d.ch_on   = wr_data[CTRL_CH_LSB +: NCH];
            end
            if (wr_addr == AW'(ADDR_DIV)) begin
                c_d.div_sh = wr_data;
            end
            if (wr_addr == AW'(ADDR_LIMIT)) begin
                c_d.lim_sh = wr_data;
            end
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == AW'(ADDR_CMP_BASE + i)) begin
                    c_d.cmp_sh[i] = wr_data;
                end
            end
        end
        load = !c_q.run || turn;
        if (load) begin
            c_d.mode_act = c_d.mode_sh;
            c_d.div_act  = c_d.div_sh;
            c_d.lim_act  = c_d.lim_sh;
            c_d.cmp_act  = c_d.cmp_sh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= CFG_RST;
        end else begin
            c_q <= c_d;
        end
    end

    pwm_prescaler #(.CW(CW)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (c_q.run),
        .div   (c_q.div_act),
        .tick  (tick)
    );

    pwm_counter #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (c_q.run),
        .tick  (tick),
        .mode  (cnt_mode_e'(c_q.mode_act)),
        .limit (c_q.lim_act),
        .cnt   (cnt),
        .turn  (turn),
        .upd   (upd_evt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel #(.CW(CW)) u_ch (
            .run (c_q.run),
            .on  (c_q.ch_on[g]),
            .cnt (cnt),
            .cmp (c_q.cmp_act[g]),
            .pwm (pwm_out[g])
        );
    end

    AST_CMP_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.run && $past(c_q.run) && !upd_evt |-> $stable(c_q.cmp_act)) else $error("compare changed mid-period"); // R6
    AST_LIMIT_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.run && $past(c_q.run) && !upd_evt |-> $stable(c_q.lim_act)) else $error("limit changed mid-period"); // R6
    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.run && !$past(c_q.run) |-> (pwm_out == '0) && !upd_evt) else $error("stopped timer active"); // R7

endmodule

// File: tb/sim_pwm_timer.sv
`timescale 1ns/1ps
module sim_pwm_timer;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        mode;
        logic [3:0]  on;
        logic [15:0] psc;
        logic [15:0] arr;
        logic [63:0] ccr;  // {ch3,ch2,ch1,ch0}
        logic [15:0] sp;   // expected cycles between update events
        logic [15:0] per;  // full period in cycles
        logic [63:0] hi;   // expected high cycles per period {ch3,ch2,ch1,ch0}
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'hF, 16'd0, 16'd9, {16'd12, 16'd10, 16'd0, 16'd3}, 16'd10, 16'd10, {16'd10, 16'd10, 16'd0, 16'd3}},
        '{1'b0, 4'hF, 16'd2, 16'd4, {16'd5, 16'd4, 16'd2, 16'd1},   16'd15, 16'd15, {16'd15, 16'd12, 16'd6, 16'd3}},
        '{1'b1, 4'hF, 16'd0, 16'd5, {16'd6, 16'd5, 16'd3, 16'd1},   16'd5,  16'd10, {16'd10, 16'd9, 16'd5, 16'd1}},
        '{1'b1, 4'hA, 16'd1, 16'd4, {16'd7, 16'd4, 16'd2, 16'd2},   16'd8,  16'd16, {16'd16, 16'd0, 16'd6, 16'd0}},
        '{1'b0, 4'hF, 16'd0, 16'd0, {16'd1, 16'd0, 16'd1, 16'd0},   16'd1,  16'd1,  {16'd1, 16'd0, 16'd1, 16'd0}},
        '{1'b0, 4'hF, 16'd3, 16'd2, {16'd0, 16'd3, 16'd2, 16'd1},   16'd12, 16'd12, {16'd0, 16'd12, 16'd8, 16'd4}}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  pwm;
    logic        upd;

    int total = 0;
    int fails = 0;

    pwm_timer u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm),
        .upd_evt (upd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write lands at the next rising edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_upd();
        int g = 0;
        while (!upd && g < 5000) begin
            @(negedge clk);
            g++;
        end
        if (!upd) check("R2 update never seen", 0, 1);
    endtask

    task automatic measure(input string tsp, input string thi, input int sp, input int per,
                           input logic [63:0] hi, input logic [3:0] on);
        int k;
        int h [4];
        wait_upd();
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!upd && k < 5000);
        check(tsp, k, sp);
        for (int c = 0; c < 4; c++) h[c] = 0;
        for (int n = 0; n < per; n++) begin
            for (int c = 0; c < 4; c++) if (pwm[c]) h[c]++;
            @(negedge clk);
        end
        for (int c = 0; c < 4; c++)
            check(on[c] ? thi : "R7 disabled channel", h[c], int'(hi[16*c +: 16]));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int hcnt;
        int ucnt;
        // reset state
        repeat (3) @(negedge clk);
        check("R7 reset pwm", int'(pwm), 0);
        check("R7 reset update", int'(upd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 after reset pwm", int'(pwm), 0);
        check("R7 after reset update", int'(upd), 0);

        // table of configurations
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, 16'd0);
            wr(3'd1, VECS[v].psc);
            wr(3'd2, VECS[v].arr);
            for (int c = 0; c < 4; c++) wr(3'(4 + c), VECS[v].ccr[16*c +: 16]);
            wr(3'd0, 16'd1 | (16'(VECS[v].mode) << 1) | (16'(VECS[v].on) << 4));
            measure(VECS[v].mode ? "R1 R3 center spacing" : "R1 R2 edge spacing",
                    "R4 R5 R9 high time", int'(VECS[v].sp), int'(VECS[v].per),
                    VECS[v].hi, VECS[v].on);
        end

        // R6: compare written mid-period is deferred to the next update
        wr(3'd0, 16'd0);
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd9);
        wr(3'd4, 16'd3);
        wr(3'd0, 16'h0011);
        wait_upd();
        wr(3'd4, 16'd8);
        hcnt = 0;
        for (int n = 0; n < 9; n++) begin
            if (pwm[0]) hcnt++;
            @(negedge clk);
        end
        check("R6 old compare kept mid-period", hcnt, 2);
        check("R6 update at period end", int'(upd), 1);
        hcnt = 0;
        for (int n = 0; n < 10; n++) begin
            if (pwm[0]) hcnt++;
            @(negedge clk);
        end
        check("R6 new compare after update", hcnt, 8);

        // R7: channel disabled while counter keeps running
        wr(3'd0, 16'h0001);
        hcnt = 0; ucnt = 0;
        for (int n = 0; n < 20; n++) begin
            if (pwm != 4'd0) hcnt++;
            if (upd) ucnt++;
            @(negedge clk);
        end
        check("R7 disabled channel low", hcnt, 0);
        check("R7 counter still running", ucnt, 2);

        // R7: timer stopped
        wr(3'd0, 16'h0000);
        @(negedge clk);
        hcnt = 0; ucnt = 0;
        for (int n = 0; n < 30; n++) begin
            if (pwm != 4'd0) hcnt++;
            if (upd) ucnt++;
            @(negedge clk);
        end
        check("R7 stopped outputs low", hcnt, 0);
        check("R7 stopped no update", ucnt, 0);

        // R8: write to unused address 3 changes nothing
        wr(3'd2, 16'd9);
        wr(3'd4, 16'd3);
        wr(3'd0, 16'h0011);
        wr(3'd3, 16'hFFFF);
        measure("R8 spacing after unused write", "R8 high time after unused write",
                10, 10, {16'd0, 16'd0, 16'd0, 16'd3}, 4'b0001);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule